// File: doc/BRIEF.md
# Parallel Bit Gather Compressor

This block takes a W-bit enable mask and a W-bit data word and moves the data bits at enabled positions down into the low end of the output. Their ascending order is kept and every higher output bit is cleared. The block is purely combinational and holds no state. A result is valid in the same time step as its inputs.

Each output position k is formed in parallel, with no loop-carried index. An exclusive prefix count of the enable mask assigns every enabled lane its destination slot. Output bit k is then the OR of the enabled data bits whose slot equals k. If the data word is tied to the enable mask, the output becomes a dense pack: a thermometer code of the enable popcount.

Top module: `bitgather_compress`

## Requirements
- R1: Bit k of `packed_out` equals `data_in` at the position of the (k+1)-th set bit of `en_mask`, counting upward from bit 0.
- R2: Every bit of `packed_out` at an index equal to or greater than the number of set bits in `en_mask` is 0.
- R3: When `data_in` equals `en_mask`, the low popcount(`en_mask`) bits of `packed_out` are 1 and all other bits are 0.
- R4: When every bit of `en_mask` is 1, `packed_out` equals `data_in`.
- R5: When `en_mask` is all zero, `packed_out` is all zero, whatever the value of `data_in`.
- R6: Data bits at positions where `en_mask` is 0 do not affect `packed_out`.
- R7: The number of set bits in `packed_out` equals the number of positions where both `en_mask` and `data_in` are 1.
- R8: The width parameter W is 4 or more. Each lane's slot count is held in $clog2(W+1) bits, so a fully set mask of any supported width is routed without wrap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| en_mask | input | W | Lane select mask; bit i set means data bit i is gathered |
| data_in | input | W | Source data word |
| packed_out | output | W | Gathered bits packed from bit 0 upward, zero filled above |

## Verification
The bound checks fire only once both inputs carry defined values, so the X state of the inputs before the first drive is excluded. The properties also assume the inputs do not change between settled evaluations. The bench meets this by changing the inputs once per clock period, shortly after a rising edge, and reading the output at the following falling edge. Stimulus includes enable masks made of replicated 4-bit groups. It also includes pairs of words that differ only at disabled lanes. A serial scan model, written in the bench, supplies every expected value.

// File: rtl/gbc_pkg.sv
package gbc_pkg;
    // Bits needed to hold a count from 0 up to w inclusive.
    function automatic int slot_bits(input int w);
        return $clog2(w + 1);
    endfunction
endpackage

// File: rtl/gbc_prefix.sv
module gbc_prefix #(
    parameter int W  = 16,
    parameter int CW = gbc_pkg::slot_bits(W)
) (
    input  logic [W-1:0]         en,
    output logic [W-1:0][CW-1:0] slot
);
    // Exclusive running count: lane i's slot is the number of enabled lanes below it.
    assign slot[0] = '0;
    for (genvar i = 1; i < W; i++) begin : g_scan
        assign slot[i] = slot[i-1] + CW'(en[i-1]);
    end
endmodule

// File: rtl/gbc_lane.sv
module gbc_lane #(
    parameter int W  = 16,
    parameter int CW = gbc_pkg::slot_bits(W),
    parameter int K  = 0
) (
    input  logic [W-1:0]         en,
    input  logic [W-1:0]         data,
    input  logic [W-1:0][CW-1:0] slot,
    output logic                 bit_o
);
    localparam logic [CW-1:0] TARGET = CW'(K);

    // Only lanes at index K or above can ever reach output slot K.
    always_comb begin
        bit_o = 1'b0;
        for (int i = K; i < W; i++) begin
            bit_o = bit_o | (en[i] & data[i] & (slot[i] == TARGET));
        end
    end
endmodule

// File: rtl/bitgather_compress.sv
module bitgather_compress #(
    parameter int W = 16
) (
    input  logic [W-1:0] en_mask,
    input  logic [W-1:0] data_in,
    output logic [W-1:0] packed_out
);
    localparam int CW = gbc_pkg::slot_bits(W);

    logic [W-1:0][CW-1:0] lane_slot;

    gbc_prefix #(.W(W), .CW(CW)) u_prefix (
        .en   (en_mask),
        .slot (lane_slot)
    );

    for (genvar k = 0; k < W; k++) begin : g_out
        gbc_lane #(.W(W), .CW(CW), .K(k)) u_lane (
            .en    (en_mask),
            .data  (data_in),
            .slot  (lane_slot),
            .bit_o (packed_out[k])
        );
    end
endmodule

// File: rtl/gbc_checks.sv
module gbc_checks #(
    parameter int W = 16
) (
    input logic [W-1:0] en_mask,
    input logic [W-1:0] data_in,
    input logic [W-1:0] packed_out
);
    int           n_en;
    logic [W:0]   ramp;
    logic [W-1:0] therm;

    initial begin
        // R8
        width_floor_chk: assert (W >= 4);
    end

    always_comb begin
        n_en  = $countones(en_mask);
        ramp  = ((W+1)'(1) << n_en) - (W+1)'(1);
        therm = ramp[W-1:0];
        if (!$isunknown({en_mask, data_in})) begin
            // R2
            tail_zero_chk: assert ((packed_out & ~therm) == '0);
            // R7
            ones_kept_chk: assert ($countones(packed_out) == $countones(en_mask & data_in));
            // R3
            if (data_in == en_mask) begin
                dense_therm_chk: assert (packed_out == therm);
            end
            // R4
            if (&en_mask) begin
                full_pass_chk: assert (packed_out == data_in);
            end
            // R5
            if (en_mask == '0) begin
                empty_zero_chk: assert (packed_out == '0);
            end
        end
    end
endmodule

bind bitgather_compress gbc_checks #(.W(W)) u_checks (
    .en_mask    (en_mask),
    .data_in    (data_in),
    .packed_out (packed_out)
);

// File: tb/bitgather_compress_test.sv
module bitgather_compress_test;
    localparam int W = 16;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic [W-1:0] en_mask = '0;
    logic [W-1:0] data_in = '0;
    logic [W-1:0] packed_out;

    int errors = 0;
    int checks = 0;
    bit done   = 1'b0;

    logic [W-1:0] exp_q[$];
    string        tag_q[$];
    logic [W-1:0] lfsr = 16'hACE1;

    always #4 clk = ~clk; // 125 MHz

    bitgather_compress #(.W(W)) uut (
        .en_mask    (en_mask),
        .data_in    (data_in),
        .packed_out (packed_out)
    );

    // Serial reference: walk lanes upward, append each enabled data bit.
    function automatic logic [W-1:0] serial_model(input logic [W-1:0] e, input logic [W-1:0] d);
        logic [W-1:0] r = '0;
        int idx = 0;
        for (int i = 0; i < W; i++) begin
            if (e[i]) begin
                r[idx] = d[i];
                idx++;
            end
        end
        return r;
    endfunction

    task automatic drive(input logic [W-1:0] e, input logic [W-1:0] d, input string tag);
        @(posedge clk);
        #1;
        en_mask = e;
        data_in = d;
        exp_q.push_back(serial_model(e, d));
        tag_q.push_back(tag);
    endtask

    function automatic logic [W-1:0] step_lfsr(input logic [W-1:0] v);
        return {v[W-2:0], v[15] ^ v[13] ^ v[12] ^ v[10]};
    endfunction

    // Monitor: compare at the falling edge after each drive.
    always @(negedge clk) begin
        if (!rst && exp_q.size() > 0) begin
            logic [W-1:0] e;
            string t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            checks++;
            if (packed_out !== e) begin
                errors++;
                $display("FAIL %s: en=%h data=%h got=%h expected=%h", t, en_mask, data_in, packed_out, e);
            end
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        // reset state: idle inputs give an all-zero output (R5)
        checks++;
        if (packed_out !== '0) begin
            errors++;
            $display("FAIL R5: reset-state got=%h expected=%h", packed_out, {W{1'b0}});
        end
        rst = 1'b0;

        // R1: directed gathers
        drive(16'h00F0, 16'h00A0, "R1");
        drive(16'h8001, 16'h8000, "R1");
        drive(16'hAAAA, 16'hFFFF, "R1");
        drive(16'h5555, 16'h1144, "R1");
        // R4: all lanes enabled
        drive(16'hFFFF, 16'h3C5A, "R4");
        drive(16'hFFFF, 16'h0000, "R4");
        // R5: nothing enabled
        drive(16'h0000, 16'hFFFF, "R5");
        drive(16'h0000, 16'h1234, "R5");
        // R3: dense pack for every popcount using scattered masks
        for (int n = 0; n <= W; n++) begin
            logic [W-1:0] m = '0;
            for (int j = 0; j < n; j++) m[(j * 7) % W] = 1'b1;
            drive(m, m, "R3");
        end
        // R6: data differing only at disabled lanes
        for (int p = 0; p < 8; p++) begin
            lfsr = step_lfsr(lfsr);
            begin
                logic [W-1:0] m = lfsr;
                lfsr = step_lfsr(lfsr);
                drive(m, lfsr, "R6");
                drive(m, lfsr ^ ~m, "R6");
            end
        end
        // R1/R7: enables replicated in groups of four
        for (int g = 0; g < 16; g++) begin
            logic [W-1:0] m;
            m = {{4{g[3]}}, {4{g[2]}}, {4{g[1]}}, {4{g[0]}}};
            lfsr = step_lfsr(lfsr);
            drive(m, lfsr, "R1_R7_groups");
        end
        // R2/R8: full mask with one-hot data at the top lane and sparse masks
        drive(16'hFFFF, 16'h8000, "R8");
        drive(16'h8000, 16'h8000, "R2");
        drive(16'h0001, 16'hFFFF, "R2");
        // R1/R2/R7: random patterns
        for (int r = 0; r < 200; r++) begin
            logic [W-1:0] m;
            lfsr = step_lfsr(lfsr);
            m = lfsr;
            lfsr = step_lfsr(lfsr);
            drive(m, lfsr, "R2_R7_rand");
        end
        repeat (3) @(posedge clk);
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: got=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule